// File: doc/BRIEF.md
# Timer Clock Source Selector

This block produces the count-enable pulse that feeds a timer's prescaler. In the default case the internal timer clock drives the prescaler, so the enable stays high every cycle. When an external clock mode is active, the enable becomes a one-cycle pulse taken from an edge on one of several inputs. Those inputs are two capture-channel pins, four internal trigger lines, and an external trigger line that has already been digitally filtered.

The source is chosen by a 3-bit slave-mode field, a 3-bit trigger-select field and a separate override bit. The override bit routes the external trigger whatever the other two fields hold. A slave-mode value of all ones opens the trigger-select path. Every input is assumed to be synchronous to the timer clock already. Each input keeps its previous sample in a register, and the selected edge is registered once more before it reaches the output. A qualifying edge therefore shows on the output in the cycle after the input changes.

Top module: `tmr_clksrc_sel`

## Requirements
- R1: While `rst_ni` is low, `cnt_en_o` is 0.
- R2: When `ext_mode1_i` is 0 and `slave_mode_i` is not 3'b111, `cnt_en_o` is 1 in every cycle after the one in which that selection is applied.
- R3: With `slave_mode_i` = 3'b111, `ext_mode1_i` = 0 and `trig_sel_i` = n (0 to 3), a rising edge on `itrig_i[n]` (0 sampled, then 1) gives `cnt_en_o` = 1 for exactly the next cycle.
- R4: A falling edge on the selected internal trigger line produces no pulse.
- R5: With `trig_sel_i` = 4 (and slave mode 3'b111), both rising and falling edges of `ch0_i` each produce a pulse.
- R6: With `trig_sel_i` = 5, only the edge of `ch0_i` chosen by `ch_pol_i` produces a pulse (0 = rising, 1 = falling).
- R7: With `trig_sel_i` = 6, only the edge of `ch1_i` chosen by `ch_pol_i` produces a pulse (0 = rising, 1 = falling).
- R8: With `trig_sel_i` = 7 (and slave mode 3'b111), a rising edge of `etr_filt_i` produces a pulse and a falling edge does not.
- R9: When `ext_mode1_i` = 1, only rising edges of `etr_filt_i` produce pulses, for any `slave_mode_i` and `trig_sel_i`.
- R10: An input held high after its edge produces a single pulse. `cnt_en_o` returns to 0 in the following cycle.
- R11: Edges on inputs other than the selected source do not change `cnt_en_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 3 | Slave-mode field; 3'b111 enables trigger-select clocking |
| trig_sel_i | input | 3 | Trigger-select field: 0-3 internal trigger, 4 ch0 both edges, 5 ch0, 6 ch1, 7 external trigger |
| ext_mode1_i | input | 1 | Override bit selecting the external trigger as the clock |
| ch_pol_i | input | 1 | Channel edge polarity: 0 rising, 1 falling |
| ch0_i | input | 1 | Capture channel 0 input |
| ch1_i | input | 1 | Capture channel 1 input |
| itrig_i | input | 4 | Internal trigger inputs |
| etr_filt_i | input | 1 | Filtered external trigger input |
| cnt_en_o | output | 1 | Prescaler count enable |

## Verification
Every source is driven with a single rising step, a held-high level and a falling step. The step separates an edge from a level and shows the one-cycle pulse width. The falling step shows whether the source follows rising edges, falling edges or both. On the channel sources, both polarity settings are tried so that the polarity input is proved to steer the edge. Edges are also placed on lines that are not selected, which exposes any mix-up in the selection decode. The override bit is driven while the slave-mode field holds a non-external value and while an internal trigger toggles, to show that the override path wins.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int unsigned N_ITRIG   = 4;
  localparam int unsigned ITRIG_IW  = $clog2(N_ITRIG);

  typedef enum logic [2:0] {
    SRC_INTERNAL = 3'd0,
    SRC_ITRIG    = 3'd1,
    SRC_CH0_BOTH = 3'd2,
    SRC_CH0_POL  = 3'd3,
    SRC_CH1_POL  = 3'd4,
    SRC_ETR      = 3'd5
  } src_kind_e;

  typedef struct packed {
    src_kind_e             kind;
    logic [ITRIG_IW-1:0]   itrig_idx;
  } src_sel_t;

endpackage

// File: rtl/tcs_src_decode.sv
module tcs_src_decode
  import tcs_pkg::*;
#(
  parameter int unsigned SM_W = 3,
  parameter int unsigned TS_W = 3
) (
  input  logic [SM_W-1:0] slave_mode_i,
  input  logic [TS_W-1:0] trig_sel_i,
  input  logic            ext_mode1_i,
  output src_sel_t        sel_o
);

  localparam logic [SM_W-1:0] SM_EXT_CLK = '1;
  localparam int unsigned     TS_CH0_BOTH = N_ITRIG;
  localparam int unsigned     TS_CH0_POL  = N_ITRIG + 1;
  localparam int unsigned     TS_CH1_POL  = N_ITRIG + 2;
  localparam int unsigned     TS_ETR      = N_ITRIG + 3;

  always_comb begin
    sel_o.kind      = SRC_INTERNAL;
    sel_o.itrig_idx = '0;
    if (ext_mode1_i) begin
      sel_o.kind = SRC_ETR;
    end else if (slave_mode_i == SM_EXT_CLK) begin
      if (int'(trig_sel_i) < N_ITRIG) begin
        sel_o.kind      = SRC_ITRIG;
        sel_o.itrig_idx = ITRIG_IW'(trig_sel_i);
      end else if (int'(trig_sel_i) == TS_CH0_BOTH) begin
        sel_o.kind = SRC_CH0_BOTH;
      end else if (int'(trig_sel_i) == TS_CH0_POL) begin
        sel_o.kind = SRC_CH0_POL;
      end else if (int'(trig_sel_i) == TS_CH1_POL) begin
        sel_o.kind = SRC_CH1_POL;
      end else if (int'(trig_sel_i) == TS_ETR) begin
        sel_o.kind = SRC_ETR;
      end
    end
  end

endmodule

// File: rtl/tcs_edge_bank.sv
module tcs_edge_bank #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d = sig_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
      end else begin
        prev_q <= prev_d;
      end
    end

    always_comb begin
      rise_o[g] =  sig_i[g] & ~prev_q;
      fall_o[g] = ~sig_i[g] &  prev_q;
    end
  end

endmodule

// File: rtl/tcs_pulse_mux.sv
module tcs_pulse_mux
  import tcs_pkg::*;
#(
  parameter int unsigned W       = 7,
  parameter int unsigned IDX_CH0 = 4,
  parameter int unsigned IDX_CH1 = 5,
  parameter int unsigned IDX_ETR = 6
) (
  input  src_sel_t     sel_i,
  input  logic         ch_pol_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic         en_o
);

  logic ch0_pol_edge;
  logic ch1_pol_edge;

  always_comb begin
    ch0_pol_edge = ch_pol_i ? fall_i[IDX_CH0] : rise_i[IDX_CH0];
    ch1_pol_edge = ch_pol_i ? fall_i[IDX_CH1] : rise_i[IDX_CH1];
  end

  always_comb begin
    unique case (sel_i.kind)
      SRC_INTERNAL: en_o = 1'b1;
      SRC_ITRIG:    en_o = rise_i[sel_i.itrig_idx];
      SRC_CH0_BOTH: en_o = rise_i[IDX_CH0] | fall_i[IDX_CH0];
      SRC_CH0_POL:  en_o = ch0_pol_edge;
      SRC_CH1_POL:  en_o = ch1_pol_edge;
      SRC_ETR:      en_o = rise_i[IDX_ETR];
      default:      en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_clksrc_sel.sv
module tmr_clksrc_sel
  import tcs_pkg::*;
#(
  parameter int unsigned SM_W = 3,
  parameter int unsigned TS_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SM_W-1:0]    slave_mode_i,
  input  logic [TS_W-1:0]    trig_sel_i,
  input  logic               ext_mode1_i,
  input  logic               ch_pol_i,
  input  logic               ch0_i,
  input  logic               ch1_i,
  input  logic [N_ITRIG-1:0] itrig_i,
  input  logic               etr_filt_i,
  output logic               cnt_en_o
);

  localparam int unsigned IDX_CH0 = N_ITRIG;
  localparam int unsigned IDX_CH1 = N_ITRIG + 1;
  localparam int unsigned IDX_ETR = N_ITRIG + 2;
  localparam int unsigned NSIG    = N_ITRIG + 3;

  src_sel_t        sel;
  logic [NSIG-1:0] sig_vec;
  logic [NSIG-1:0] rise_vec;
  logic [NSIG-1:0] fall_vec;
  logic            en_d;
  logic            en_q;

  always_comb begin
    sig_vec = {etr_filt_i, ch1_i, ch0_i, itrig_i};
  end

  tcs_src_decode #(
    .SM_W (SM_W),
    .TS_W (TS_W)
  ) u_decode (
    .slave_mode_i (slave_mode_i),
    .trig_sel_i   (trig_sel_i),
    .ext_mode1_i  (ext_mode1_i),
    .sel_o        (sel)
  );

  tcs_edge_bank #(
    .W (NSIG)
  ) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_vec),
    .rise_o (rise_vec),
    .fall_o (fall_vec)
  );

  tcs_pulse_mux #(
    .W       (NSIG),
    .IDX_CH0 (IDX_CH0),
    .IDX_CH1 (IDX_CH1),
    .IDX_ETR (IDX_ETR)
  ) u_mux (
    .sel_i    (sel),
    .ch_pol_i (ch_pol_i),
    .rise_i   (rise_vec),
    .fall_i   (fall_vec),
    .en_o     (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign cnt_en_o = en_q;

endmodule

// File: rtl/tcs_clksrc_chk.sv
module tcs_clksrc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] slave_mode_i,
  input logic [2:0] trig_sel_i,
  input logic       ext_mode1_i,
  input logic       ch_pol_i,
  input logic       ch0_i,
  input logic       ch1_i,
  input logic [3:0] itrig_i,
  input logic       etr_filt_i,
  input logic       cnt_en_o
);

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !cnt_en_o);

  assert_internal_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode1_i && slave_mode_i != 3'b111) |=> cnt_en_o);

  assert_itrig0_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode1_i && slave_mode_i == 3'b111 && trig_sel_i == 3'd0 &&
     itrig_i[0] && !$past(itrig_i[0])) |=> cnt_en_o);

  assert_itrig_low_no_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode1_i && slave_mode_i == 3'b111 && trig_sel_i < 3'd4 &&
     !itrig_i[trig_sel_i[1:0]]) |=> !cnt_en_o);

  assert_ch1_rise_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode1_i && slave_mode_i == 3'b111 && trig_sel_i == 3'd6 &&
     !ch_pol_i && !ch1_i) |=> !cnt_en_o);

  assert_etr_override_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode1_i && etr_filt_i && !$past(etr_filt_i)) |=> cnt_en_o);

  assert_etr_override_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode1_i && !etr_filt_i) |=> !cnt_en_o);

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode1_i && etr_filt_i && $past(etr_filt_i)) |=> !cnt_en_o);

endmodule

bind tmr_clksrc_sel tcs_clksrc_chk chk_i (.*);

// File: tb/tmr_clksrc_sel_tb_top.sv
module tmr_clksrc_sel_tb_top;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic [2:0] sm;
  logic [2:0] ts;
  logic       m1;
  logic       pol;
  logic       c0;
  logic       c1;
  logic [3:0] it;
  logic       etr;
  logic       en;

  logic [2:0] s_sm;
  logic [2:0] s_ts;
  logic       s_m1;
  logic       s_pol;
  logic       s_c0;
  logic       s_c1;
  logic [3:0] s_it;
  logic       s_etr;

  item_t q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  tmr_clksrc_sel dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .slave_mode_i (sm),
    .trig_sel_i   (ts),
    .ext_mode1_i  (m1),
    .ch_pol_i     (pol),
    .ch0_i        (c0),
    .ch1_i        (c1),
    .itrig_i      (it),
    .etr_filt_i   (etr),
    .cnt_en_o     (en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic exp, input string tag);
    n_checks++;
    if (en !== exp) begin
      n_errors++;
      $display("FAIL %s: cnt_en_o=%b expected %b at %0t", tag, en, exp, $time);
    end
  endtask

  task automatic step(input logic exp, input string tag);
    item_t it_e;
    @(negedge clk);
    sm = s_sm; ts = s_ts; m1 = s_m1; pol = s_pol;
    c0 = s_c0; c1 = s_c1; it = s_it; etr = s_etr;
    it_e.exp = exp;
    it_e.tag = tag;
    q.push_back(it_e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t cur;
      cur = q.pop_front();
      #2;
      check(cur.exp, cur.tag);
    end
  end

  initial begin
    rst_n = 1'b0;
    s_sm = 3'd0; s_ts = 3'd0; s_m1 = 1'b0; s_pol = 1'b0;
    s_c0 = 1'b0; s_c1 = 1'b0; s_it = 4'd0; s_etr = 1'b0;
    sm = 3'd0; ts = 3'd0; m1 = 1'b0; pol = 1'b0;
    c0 = 1'b0; c1 = 1'b0; it = 4'd0; etr = 1'b0;
    repeat (4) @(negedge clk);
    check(1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    // internal clock
    step(1'b1, "R2");
    s_sm = 3'd3; step(1'b1, "R2");

    // internal triggers
    s_sm = 3'd7; s_ts = 3'd0; step(1'b0, "R3");
    s_it = 4'b0001; step(1'b1, "R3");
    step(1'b0, "R10");
    s_it = 4'b0000; step(1'b0, "R4");
    s_ts = 3'd3; s_it = 4'b1000; step(1'b1, "R3");
    s_it = 4'b1100; step(1'b0, "R11");
    s_it = 4'b0000; step(1'b0, "R4");

    // channel 0 both edges
    s_ts = 3'd4; s_c0 = 1'b1; step(1'b1, "R5");
    s_c0 = 1'b0; step(1'b1, "R5");
    step(1'b0, "R5");

    // channel 0 with polarity
    s_ts = 3'd5; s_pol = 1'b0; s_c0 = 1'b1; step(1'b1, "R6");
    s_c0 = 1'b0; step(1'b0, "R6");
    s_pol = 1'b1; s_c0 = 1'b1; step(1'b0, "R6");
    s_c0 = 1'b0; step(1'b1, "R6");

    // channel 1 with polarity
    s_ts = 3'd6; s_pol = 1'b0; s_c0 = 1'b1; step(1'b0, "R11");
    s_c1 = 1'b1; step(1'b1, "R7");
    s_c1 = 1'b0; step(1'b0, "R7");
    s_pol = 1'b1; s_c1 = 1'b1; step(1'b0, "R7");
    s_c1 = 1'b0; s_c0 = 1'b0; step(1'b1, "R7");

    // external trigger through trigger select
    s_ts = 3'd7; s_etr = 1'b1; step(1'b1, "R8");
    step(1'b0, "R10");
    s_etr = 1'b0; step(1'b0, "R8");

    // override bit
    s_m1 = 1'b1; s_sm = 3'd0; step(1'b0, "R9");
    s_etr = 1'b1; step(1'b1, "R9");
    s_etr = 1'b0; step(1'b0, "R9");
    s_sm = 3'd7; s_ts = 3'd0; s_it = 4'b0001; step(1'b0, "R9");
    s_etr = 1'b1; step(1'b1, "R9");

    // back to internal
    s_m1 = 1'b0; s_sm = 3'd2; s_etr = 1'b0; s_it = 4'b0000; step(1'b1, "R2");

    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (2000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule